// File: doc/BRIEF.md
# Dual-Clock Compare-Match Timer

This block keeps a 32-bit up-counter in a slow timer clock domain and raises a level interrupt when the count equals a programmed compare value. A processor reaches it through a small register port in the bus clock domain. The processor never samples the moving counter directly. It asks for a capture, waits for a busy flag to drop, and then reads a stable copy. Loads of the counter and of the compare value are also handed over to the timer domain one at a time, and each hand-over has its own busy flag.

Each crossing uses a toggle request and a toggle acknowledge, and each passes through a synchronizer chain of configurable depth. A compare hit in the timer domain is sent back to the bus domain as a toggle event. There it sets a sticky flag, which the software clears by writing a one. Software normally schedules the next event at least sixteen ticks ahead of the current count. That margin covers the crossing latency.

Top module: `match_timer`

## Requirements
- R1: After reset the counter is zero and stopped, the compare value (read at 0x00) is all ones, the captured count (0x10), flags (0x14), interrupt enables (0x1C), control (0x20) and access status (0x24) all read zero, and irq is low.
- R2: While control bit 0 is 1 the counter adds one on every timer clock edge and wraps from 0xFFFFFFFF to 0. While bit 0 is 0 it holds its value.
- R3: Writing control with bit 1 set asks for a capture of the live count. Access-status bit 5 reads 1 from the next bus cycle until the captured value is readable at 0x10, and then reads 0.
- R4: A write to 0x10 loads the counter in the timer domain. Access-status bit 4 reads 1 from the next bus cycle until the load has been carried out.
- R5: A write to 0x00 sets the compare value in the timer domain. Access-status bit 0 reads 1 from the next bus cycle until it takes effect. Reading 0x00 returns the last accepted compare value.
- R6: A count write, a compare write or a capture request that arrives while its own busy bit is 1 is ignored.
- R7: Flag bit 0 at 0x14 becomes 1 after a timer clock edge at which the running count equals the compare value. It stays 1 until software clears it. Flag bits 3:1 always read 0.
- R8: Writing 1 to flag bit 0 clears it. Writing 0 leaves it unchanged.
- R9: irq is the OR of the flag bits ANDed with the enable bits stored in bits 3:0 at 0x1C. It is a level output.
- R10: The flag does not become 1 before the counter has reached the compare value.
- R11: Control bit 0 reads back as the enable. Control bit 1 is a request only and always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| tclk | input | 1 | Timer clock (slow) |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| addr | input | 6 | Register byte offset |
| wdata | input | 32 | Write data |
| wr | input | 1 | Write strobe, sampled on clk |
| rdata | output | 32 | Read data for the register at addr (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit counter and two synchronizer stages in each direction. The timer clock runs ten times slower than the bus clock, so every crossing takes tens of bus cycles. That leaves room to observe the busy flags and to send a second write while the first is still in flight. Because the counter is 32 bits wide, wrap-around is reached by loading a count a few ticks below 2^32 and placing the compare value just past zero.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
    localparam int ADDR_W = 6;
    localparam int FLAG_W = 4;

    localparam logic [ADDR_W-1:0] OFF_MATCH  = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_IEN    = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_ACC    = 6'h24;

    localparam int ACC_MATCH_BIT = 0;
    localparam int ACC_CWR_BIT   = 4;
    localparam int ACC_CRD_BIT   = 5;
endpackage

// File: rtl/match_timer_sync.sv
module match_timer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= 1'b0;
                else        stage_q[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= 1'b0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/match_timer_core.sv
module match_timer_core #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             tclk,
    input  logic             rst_n,
    input  logic             en_a,
    input  logic             cnt_req_a,
    input  logic [CNT_W-1:0] cnt_data,
    input  logic             mat_req_a,
    input  logic [CNT_W-1:0] mat_data,
    input  logic             snp_req_a,
    output logic             cnt_ack,
    output logic             mat_ack,
    output logic             snp_ack,
    output logic             evt_tgl,
    output logic [CNT_W-1:0] snap_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ld_o,
    output logic             en_o
);
    localparam int N_IN = 4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] match;
        logic [CNT_W-1:0] snap;
        logic             cnt_seen;
        logic             mat_seen;
        logic             snp_seen;
        logic             evt;
    } core_t;

    core_t core_d, core_q;
    logic [N_IN-1:0] in_a, in_s;
    logic en_s, cnt_s, mat_s, snp_s, load;

    assign in_a = {snp_req_a, mat_req_a, cnt_req_a, en_a};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        match_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (tclk),
            .rst_n(rst_n),
            .d    (in_a[g]),
            .q    (in_s[g])
        );
    end

    assign {snp_s, mat_s, cnt_s, en_s} = in_s;
    assign load = cnt_s != core_q.cnt_seen;

    always_comb begin
        core_d = core_q;
        if (load) begin
            core_d.cnt      = cnt_data;
            core_d.cnt_seen = cnt_s;
        end else if (en_s) begin
            core_d.cnt = core_q.cnt + CNT_W'(1);
            if (core_q.cnt == core_q.match) core_d.evt = ~core_q.evt;
        end
        if (mat_s != core_q.mat_seen) begin
            core_d.match    = mat_data;
            core_d.mat_seen = mat_s;
        end
        if (snp_s != core_q.snp_seen) begin
            core_d.snap     = core_q.cnt;
            core_d.snp_seen = snp_s;
        end
    end

    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n) begin
            core_q       <= '0;
            core_q.match <= '1;
        end else begin
            core_q <= core_d;
        end
    end

    assign cnt_ack = core_q.cnt_seen;
    assign mat_ack = core_q.mat_seen;
    assign snp_ack = core_q.snp_seen;
    assign evt_tgl = core_q.evt;
    assign snap_o  = core_q.snap;
    assign cnt_o   = core_q.cnt;
    assign ld_o    = load;
    assign en_o    = en_s;
endmodule

// File: rtl/match_timer_regs.sv
module match_timer_regs
    import match_timer_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              wr,
    input  logic              cnt_ack_a,
    input  logic              mat_ack_a,
    input  logic              snp_ack_a,
    input  logic              evt_a,
    input  logic [CNT_W-1:0]  snap_data,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq,
    output logic              en_o,
    output logic              cnt_req_o,
    output logic              mat_req_o,
    output logic              snp_req_o,
    output logic [CNT_W-1:0]  cnt_hold_o,
    output logic [CNT_W-1:0]  mat_hold_o,
    output logic              busy_cnt_o,
    output logic              busy_mat_o,
    output logic              busy_snp_o,
    output logic              flag_o,
    output logic              evt_new_o,
    output logic [FLAG_W-1:0] ien_o
);
    localparam int N_IN = 4;

    typedef struct packed {
        logic [CNT_W-1:0]  mat_hold;
        logic [CNT_W-1:0]  cnt_hold;
        logic [CNT_W-1:0]  rd_cnt;
        logic              en;
        logic [FLAG_W-1:0] ien;
        logic              flag;
        logic              req_cnt;
        logic              req_mat;
        logic              req_snp;
        logic              done_cnt;
        logic              done_mat;
        logic              done_snp;
        logic              evt_seen;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [N_IN-1:0] in_a, in_s;
    logic cack_s, mack_s, sack_s, evt_s;
    logic busy_c, busy_m, busy_s, evt_new;
    logic [FLAG_W-1:0] flags;

    assign in_a = {evt_a, snp_ack_a, mat_ack_a, cnt_ack_a};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        match_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (in_a[g]),
            .q    (in_s[g])
        );
    end

    assign {evt_s, sack_s, mack_s, cack_s} = in_s;

    assign busy_c  = regs_q.req_cnt ^ regs_q.done_cnt;
    assign busy_m  = regs_q.req_mat ^ regs_q.done_mat;
    assign busy_s  = regs_q.req_snp ^ regs_q.done_snp;
    assign evt_new = evt_s != regs_q.evt_seen;

    always_comb begin
        regs_d          = regs_q;
        regs_d.done_cnt = cack_s;
        regs_d.done_mat = mack_s;
        regs_d.evt_seen = evt_s;
        if (sack_s != regs_q.done_snp) begin
            regs_d.rd_cnt   = snap_data;
            regs_d.done_snp = sack_s;
        end
        if (wr) begin
            unique case (addr)
                OFF_MATCH: if (!busy_m) begin
                    regs_d.mat_hold = wdata;
                    regs_d.req_mat  = ~regs_q.req_mat;
                end
                OFF_COUNT: if (!busy_c) begin
                    regs_d.cnt_hold = wdata;
                    regs_d.req_cnt  = ~regs_q.req_cnt;
                end
                OFF_STATUS: if (wdata[0]) regs_d.flag = 1'b0;
                OFF_IEN:    regs_d.ien = wdata[FLAG_W-1:0];
                OFF_CTRL: begin
                    regs_d.en = wdata[0];
                    if (wdata[1] && !busy_s) regs_d.req_snp = ~regs_q.req_snp;
                end
                default: ;
            endcase
        end
        if (evt_new) regs_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q          <= '0;
            regs_q.mat_hold <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign flags = {{(FLAG_W-1){1'b0}}, regs_q.flag};

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_MATCH:  rdata = regs_q.mat_hold;
            OFF_COUNT:  rdata = regs_q.rd_cnt;
            OFF_STATUS: rdata[FLAG_W-1:0] = flags;
            OFF_IEN:    rdata[FLAG_W-1:0] = regs_q.ien;
            OFF_CTRL:   rdata[0] = regs_q.en;
            OFF_ACC: begin
                rdata[ACC_MATCH_BIT] = busy_m;
                rdata[ACC_CWR_BIT]   = busy_c;
                rdata[ACC_CRD_BIT]   = busy_s;
            end
            default: rdata = '0;
        endcase
    end

    assign irq        = |(flags & regs_q.ien);
    assign en_o       = regs_q.en;
    assign cnt_req_o  = regs_q.req_cnt;
    assign mat_req_o  = regs_q.req_mat;
    assign snp_req_o  = regs_q.req_snp;
    assign cnt_hold_o = regs_q.cnt_hold;
    assign mat_hold_o = regs_q.mat_hold;
    assign busy_cnt_o = busy_c;
    assign busy_mat_o = busy_m;
    assign busy_snp_o = busy_s;
    assign flag_o     = regs_q.flag;
    assign evt_new_o  = evt_new;
    assign ien_o      = regs_q.ien;
endmodule

// File: rtl/match_timer.sv
module match_timer
    import match_timer_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              tclk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              wr,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);
    logic             en_w, cnt_req_w, mat_req_w, snp_req_w;
    logic [CNT_W-1:0] cnt_hold_w, mat_hold_w, snap_w, t_cnt;
    logic             cnt_ack_w, mat_ack_w, snp_ack_w, evt_w;
    logic             busy_cnt, busy_mat, busy_snp, flag, evt_new;
    logic [FLAG_W-1:0] ien;
    logic             t_ld, t_en;

    match_timer_regs #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wdata     (wdata),
        .wr        (wr),
        .cnt_ack_a (cnt_ack_w),
        .mat_ack_a (mat_ack_w),
        .snp_ack_a (snp_ack_w),
        .evt_a     (evt_w),
        .snap_data (snap_w),
        .rdata     (rdata),
        .irq       (irq),
        .en_o      (en_w),
        .cnt_req_o (cnt_req_w),
        .mat_req_o (mat_req_w),
        .snp_req_o (snp_req_w),
        .cnt_hold_o(cnt_hold_w),
        .mat_hold_o(mat_hold_w),
        .busy_cnt_o(busy_cnt),
        .busy_mat_o(busy_mat),
        .busy_snp_o(busy_snp),
        .flag_o    (flag),
        .evt_new_o (evt_new),
        .ien_o     (ien)
    );

    match_timer_core #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .tclk     (tclk),
        .rst_n    (rst_n),
        .en_a     (en_w),
        .cnt_req_a(cnt_req_w),
        .cnt_data (cnt_hold_w),
        .mat_req_a(mat_req_w),
        .mat_data (mat_hold_w),
        .snp_req_a(snp_req_w),
        .cnt_ack  (cnt_ack_w),
        .mat_ack  (mat_ack_w),
        .snp_ack  (snp_ack_w),
        .evt_tgl  (evt_w),
        .snap_o   (snap_w),
        .cnt_o    (t_cnt),
        .ld_o     (t_ld),
        .en_o     (t_en)
    );
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
    import match_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              tclk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wdata,
    input logic              wr,
    input logic              irq,
    input logic              busy_cnt,
    input logic              busy_mat,
    input logic              busy_snp,
    input logic              flag,
    input logic              evt_new,
    input logic [FLAG_W-1:0] ien,
    input logic [CNT_W-1:0]  t_cnt,
    input logic              t_ld,
    input logic              t_en
);
    assert_count_step_R2: assert property (@(posedge tclk) disable iff (!rst_n)
        (t_en && !t_ld) |=> (t_cnt == $past(t_cnt) + CNT_W'(1)));

    assert_count_hold_R2: assert property (@(posedge tclk) disable iff (!rst_n)
        (!t_en && !t_ld) |=> $stable(t_cnt));

    assert_snap_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFF_CTRL && wdata[1] && !busy_snp) |=> busy_snp);

    assert_cnt_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFF_COUNT && !busy_cnt) |=> busy_cnt);

    assert_mat_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFF_MATCH && !busy_mat) |=> busy_mat);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr && addr == OFF_STATUS && wdata[0])) |=> flag);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFF_STATUS && wdata[0] && !evt_new) |=> !flag);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ien[0] |-> !irq);

    assert_irq_raised_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ien[0]) |-> irq);
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .tclk    (tclk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .wr      (wr),
    .irq     (irq),
    .busy_cnt(busy_cnt),
    .busy_mat(busy_mat),
    .busy_snp(busy_snp),
    .flag    (flag),
    .evt_new (evt_new),
    .ien     (ien),
    .t_cnt   (t_cnt),
    .t_ld    (t_ld),
    .t_en    (t_en)
);

// File: tb/match_timer_test.sv
module match_timer_test;
    import match_timer_pkg::*;

    localparam int NROW = 4;
    localparam logic [31:0] ROW_LOAD [NROW] = '{32'h0000_0000, 32'h1234_5678, 32'hFFFF_FFF8, 32'h7FFF_FFF0};
    localparam int          ROW_DIST [NROW] = '{20, 17, 24, 40};

    logic        clk = 1'b0;
    logic        tclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;

    always #2  clk  = ~clk;
    always #20 tclk = ~tclk;

    match_timer uut (
        .clk  (clk),
        .tclk (tclk),
        .rst_n(rst_n),
        .addr (addr),
        .wdata(wdata),
        .wr   (wr),
        .rdata(rdata),
        .irq  (irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic chk_range(input string req, input logic [31:0] got,
                             input logic [31:0] lo, input logic [31:0] hi);
        checks++;
        if (got < lo || got > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, got, lo, hi);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wait_idle(input int bitpos, input string req);
        logic [31:0] v;
        int n = 0;
        do begin
            bus_rd(OFF_ACC, v);
            n++;
        end while (v[bitpos] && n < 400);
        chk(req, {31'b0, v[bitpos]}, 32'd0);
    endtask

    task automatic snapshot(input logic en, output logic [31:0] v);
        bus_wr(OFF_CTRL, {30'b0, 1'b1, en});
        wait_idle(ACC_CRD_BIT, "R3 capture done");
        bus_rd(OFF_COUNT, v);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] v, a, b;
        repeat (5) @(posedge tclk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(OFF_MATCH, v);  chk("R1 match", v, 32'hFFFF_FFFF);
        bus_rd(OFF_COUNT, v);  chk("R1 count", v, 32'h0);
        bus_rd(OFF_STATUS, v); chk("R1 status", v, 32'h0);
        bus_rd(OFF_IEN, v);    chk("R1 ien", v, 32'h0);
        bus_rd(OFF_CTRL, v);   chk("R1 ctrl", v, 32'h0);
        bus_rd(OFF_ACC, v);    chk("R1 acc", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 counter stopped after reset
        repeat (30) @(posedge tclk);
        snapshot(1'b0, v); chk("R2 stopped after reset", v, 32'h0);

        // R3 busy visible right after request
        bus_wr(OFF_CTRL, 32'h2);
        bus_rd(OFF_ACC, v); chk("R3 busy bit5", {31'b0, v[ACC_CRD_BIT]}, 32'h1);
        wait_idle(ACC_CRD_BIT, "R3 busy drops");

        // R4 count load
        bus_wr(OFF_COUNT, 32'd100);
        bus_rd(OFF_ACC, v); chk("R4 busy bit4", {31'b0, v[ACC_CWR_BIT]}, 32'h1);
        wait_idle(ACC_CWR_BIT, "R4 busy drops");
        snapshot(1'b0, v); chk("R4 loaded count", v, 32'd100);

        // R6 second count write while busy is dropped
        bus_wr(OFF_COUNT, 32'h0000_AAAA);
        bus_wr(OFF_COUNT, 32'h0000_5555);
        wait_idle(ACC_CWR_BIT, "R6 count idle");
        snapshot(1'b0, v); chk("R6 count write ignored", v, 32'h0000_AAAA);

        // R5 / R6 compare write and readback
        bus_wr(OFF_MATCH, 32'h1111_0000);
        bus_rd(OFF_ACC, v); chk("R5 busy bit0", {31'b0, v[ACC_MATCH_BIT]}, 32'h1);
        bus_wr(OFF_MATCH, 32'h2222_0000);
        wait_idle(ACC_MATCH_BIT, "R5 busy drops");
        bus_rd(OFF_MATCH, v); chk("R5 R6 compare readback", v, 32'h1111_0000);

        // R11 control readback
        bus_wr(OFF_CTRL, 32'h3);
        bus_rd(OFF_CTRL, v); chk("R11 ctrl reads enable only", v, 32'h1);
        wait_idle(ACC_CRD_BIT, "R11 capture idle");

        // R2 counting rate
        repeat (100) @(posedge tclk);
        snapshot(1'b1, a);
        repeat (50) @(posedge tclk);
        snapshot(1'b1, b);
        chk_range("R2 advance per tick", b - a, 32'd50, 32'd70);

        // R2 hold while disabled
        bus_wr(OFF_CTRL, 32'h0);
        bus_rd(OFF_CTRL, v); chk("R11 ctrl cleared", v, 32'h0);
        repeat (10) @(posedge tclk);
        snapshot(1'b0, a);
        repeat (40) @(posedge tclk);
        snapshot(1'b0, b);
        chk("R2 hold when disabled", b, a);

        // Table of load / distance rows: R7, R9, R10, wrap for R2
        bus_wr(OFF_IEN, 32'h1);
        for (int r = 0; r < NROW; r++) begin
            logic [31:0] s;
            int n;
            bus_wr(OFF_CTRL, 32'h0);
            repeat (10) @(posedge tclk);
            bus_wr(OFF_COUNT, ROW_LOAD[r]);
            wait_idle(ACC_CWR_BIT, "R4 row load");
            bus_wr(OFF_MATCH, ROW_LOAD[r] + 32'(ROW_DIST[r]));
            wait_idle(ACC_MATCH_BIT, "R5 row compare");
            bus_wr(OFF_STATUS, 32'hF);
            bus_rd(OFF_STATUS, v); chk("R8 row clear", v, 32'h0);
            bus_wr(OFF_CTRL, 32'h1);
            repeat ((ROW_DIST[r] / 2) * 10) @(negedge clk);
            bus_rd(OFF_STATUS, v); chk("R10 no early flag", v, 32'h0);
            n = 0;
            do begin
                bus_rd(OFF_STATUS, v);
                n++;
            end while (v == 32'h0 && n < 3000);
            chk("R7 flag set, upper bits zero", v, 32'h1);
            chk("R9 irq follows flag", {31'b0, irq}, 32'h1);
            snapshot(1'b1, s);
            chk_range("R2 count past compare (wrap row 2)", s - ROW_LOAD[r],
                      32'(ROW_DIST[r]), 32'(ROW_DIST[r] + 40));
        end

        // R7 flag stays while counter keeps running
        repeat (100) @(posedge tclk);
        bus_rd(OFF_STATUS, v); chk("R7 flag sticky", v, 32'h1);

        // R9 masking
        bus_wr(OFF_IEN, 32'h0);
        @(negedge clk); chk("R9 irq masked", {31'b0, irq}, 32'h0);
        bus_rd(OFF_IEN, v); chk("R9 ien readback", v, 32'h0);
        bus_rd(OFF_STATUS, v); chk("R9 flag kept while masked", v, 32'h1);

        // R8 writing zero does nothing, writing one clears
        bus_wr(OFF_STATUS, 32'h0);
        bus_rd(OFF_STATUS, v); chk("R8 write zero keeps flag", v, 32'h1);
        bus_wr(OFF_IEN, 32'h1);
        @(negedge clk); chk("R9 irq unmasked", {31'b0, irq}, 32'h1);
        bus_wr(OFF_STATUS, 32'h1);
        bus_rd(OFF_STATUS, v); chk("R8 write one clears", v, 32'h0);
        chk("R9 irq drops with flag", {31'b0, irq}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule